// File: doc/BRIEF.md
# Per-Core One-Shot Event Timer Bank

This block gives every processor core in a cluster its own private event timer. All cores share one free-running tick counter, and each core has its own countdown, enable, status and interrupt line. Software on a core arms a single event by writing a relative tick count. When that many clock ticks have passed, the core's interrupt line rises and stays high until software clears it. Software that wants another event writes a new count.

Each core reaches its registers through a narrow register port instead of a memory map. The port carries a register index, a write strobe and write data, and returns read data. Reads are combinational. A write takes effect at the clock edge on which the strobe is high. The register indices are sparse: control is 0, status is 1, the shared counter is 3 and the event reload is 6. The core count, the counter width and the index width are parameters.

Top module: `core_event_timer_bank`

## Requirements
- R1: The shared counter is zero during reset. It increments by one on every clock edge after reset, wraps modulo 2^CNT_W and never stops. Reading index 3 on any core returns its current value.
- R2: Writing index 0 sets the core's enable bit from write-data bit 0. Reading index 0 returns the enable in bit 0 and zeros elsewhere. Enable is 0 after reset.
- R3: Writing a nonzero delta D to index 6 on clock edge t arms an event. If the core is enabled, its interrupt is low up to edge t+D-1 and high after edge t+D.
- R4: Writing index 6 while a countdown is in progress cancels it. Counting restarts from the new value, and the old expiry does not happen.
- R5: An expired event does not re-arm. No further interrupt occurs until index 6 is written again.
- R6: Expiry sets the interrupt status only if the core is enabled at that edge. A pending status stays set when the core is later disabled.
- R7: Writing the value 0 to index 1 clears the core's pending status, and writing any nonzero value there has no effect. Reading index 1 returns the pending status in bit 0. The interrupt output equals the pending status.
- R8: Reads of index 6 and of any unused index return zero. Writes to unused indices change no state.
- R9: The cores' timers are independent. One core's writes never affect another core's enable, countdown or interrupt.
- R10: Writing a delta of 0 to index 6 cancels any countdown and arms nothing.
- R11: If a status clear and an expiry fall on the same edge, the expiry wins and the status is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock; one tick per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | NUM_CORES*IDX_W | Per-core register index, core c in slice c |
| reg_we | input | NUM_CORES | Per-core write strobe |
| reg_wdata | input | NUM_CORES*CNT_W | Per-core write data |
| reg_rdata | output | NUM_CORES*CNT_W | Per-core combinational read data |
| irq | output | NUM_CORES | Per-core interrupt, high while status pending |

## Verification
The bench uses an 8-bit counter, so wrap-around can be observed. A counter that stopped or saturated would return a value other than the cycle count modulo 256. Deltas from 1 up to the maximum of 255 are swept on both cores, checking every cycle. An off-by-one countdown would raise the interrupt one cycle early or late. A periodic reload would fire a second time during the idle wait. A reload that does not cancel would fire at the old expiry. Further tests cover expiry while disabled, a zero delta, a clear on the expiry edge, and writes to unused indices. A design that got any of these wrong would leave a status bit set or cleared when it should not be.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
   localparam int unsigned MIN_IDX_W  = 3;
   localparam logic [2:0]  IDX_CTRL   = 3'd0;
   localparam logic [2:0]  IDX_STATUS = 3'd1;
   localparam logic [2:0]  IDX_NOW    = 3'd3;
   localparam logic [2:0]  IDX_RELOAD = 3'd6;
endpackage

// File: rtl/shared_tick_counter.sv
module shared_tick_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   // R1: advances by exactly one every cycle, wrapping
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> count == W'($past(count) + 1'b1));
endmodule

// File: rtl/core_event_unit.sv
module core_event_unit
   import evt_timer_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     now,
   input  logic [IDX_W-1:0] idx,
   input  logic             we,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata,
   output logic             irq
);
   localparam logic [IDX_W-1:0] I_CTRL   = IDX_W'(IDX_CTRL);
   localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(IDX_STATUS);
   localparam logic [IDX_W-1:0] I_NOW    = IDX_W'(IDX_NOW);
   localparam logic [IDX_W-1:0] I_RELOAD = IDX_W'(IDX_RELOAD);

   logic         enable, armed, pending;
   logic [W-1:0] remain;
   logic         wr_ctrl, wr_status, wr_reload, clear_req, expire;

   assign wr_ctrl   = we && (idx == I_CTRL);
   assign wr_status = we && (idx == I_STATUS);
   assign wr_reload = we && (idx == I_RELOAD);
   assign clear_req = wr_status && (wdata == '0);
   // a reload on the expiry edge replaces the old event
   assign expire    = armed && (remain == W'(1)) && !wr_reload;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable  <= 1'b0;
         armed   <= 1'b0;
         remain  <= '0;
         pending <= 1'b0;
      end else begin
         if (wr_ctrl) enable <= wdata[0];
         if (wr_reload) begin
            armed  <= (wdata != '0);
            remain <= wdata;
         end else if (armed) begin
            remain <= remain - 1'b1;
            if (expire) armed <= 1'b0;
         end
         if (expire && enable) pending <= 1'b1;
         else if (clear_req)   pending <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      case (idx)
         I_CTRL:   rdata[0] = enable;
         I_STATUS: rdata[0] = pending;
         I_NOW:    rdata    = now;
         default:  rdata    = '0;
      endcase
   end

   assign irq = pending;

   // R3: enabled expiry raises status on the next cycle
   p_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed && remain == W'(1) && enable && !wr_reload |=> pending);
   // R5: expiry leaves the unit idle
   p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && remain == W'(1) && !wr_reload |=> !armed);
   // R6: status cannot appear while disabled
   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !pending |=> !pending);
   // R7: status holds until a zero write to the status index
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !(we && idx == I_STATUS && wdata == '0) |=> pending);
   // R10: zero delta arms nothing
   p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      we && idx == I_RELOAD && wdata == '0 |=> !armed);
endmodule

// File: rtl/core_event_timer_bank.sv
module core_event_timer_bank
   import evt_timer_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned IDX_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CORES*IDX_W-1:0] reg_idx,
   input  logic [NUM_CORES-1:0]       reg_we,
   input  logic [NUM_CORES*CNT_W-1:0] reg_wdata,
   output logic [NUM_CORES*CNT_W-1:0] reg_rdata,
   output logic [NUM_CORES-1:0]       irq
);
   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("NUM_CORES must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_width
         $error("CNT_W must be at least 2");
      end
      if (IDX_W < MIN_IDX_W) begin : g_bad_idx
         $error("IDX_W too narrow for register indices");
      end
   endgenerate

   logic [CNT_W-1:0] now;

   shared_tick_counter #(.W(CNT_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .count (now)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      core_event_unit #(.W(CNT_W), .IDX_W(IDX_W)) u_unit (
         .clk   (clk),
         .rst_n (rst_n),
         .now   (now),
         .idx   (reg_idx[c*IDX_W +: IDX_W]),
         .we    (reg_we[c]),
         .wdata (reg_wdata[c*CNT_W +: CNT_W]),
         .rdata (reg_rdata[c*CNT_W +: CNT_W]),
         .irq   (irq[c])
      );
   end
endmodule

// File: tb/core_event_timer_bank_test.sv
module core_event_timer_bank_test;
   localparam int NC = 2;
   localparam int W  = 8;
   localparam int IW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NC*IW-1:0] reg_idx = '0;
   logic [NC-1:0]   reg_we = '0;
   logic [NC*W-1:0] reg_wdata = '0;
   logic [NC*W-1:0] reg_rdata;
   logic [NC-1:0]   irq;

   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   core_event_timer_bank #(.NUM_CORES(NC), .CNT_W(W), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int c, input int i, input int d);
      reg_idx[c*IW +: IW] = IW'(i);
      reg_wdata[c*W +: W] = W'(d);
      reg_we[c] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_we[c] = 1'b0;
   endtask

   task automatic rd(input int c, input int i, output logic [31:0] v);
      reg_idx[c*IW +: IW] = IW'(i);
      #1;
      v = 32'(reg_rdata[c*W +: W]);
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // R3: arm and check the exact firing cycle
   task automatic fire(input int c, input int d);
      wr(c, 6, d);
      for (int k = 1; k < d; k++) begin
         @(negedge clk);
         chk("R3 early", 32'(irq[c]), 0);
      end
      @(negedge clk);
      chk("R3 fire", 32'(irq[c]), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int deltas [6] = '{1, 2, 3, 5, 17, 255};
      @(negedge clk);
      @(negedge clk);
      // reset state
      rd(0, 3, v); chk("R1 reset count", v, 0);
      chk("R7 reset irq", 32'(irq), 0);
      rd(0, 0, v); chk("R2 reset enable", v, 0);
      rst_n = 1'b1;
      rd(1, 3, v); chk("R1 count at release", v, 0);
      wait_n(300);
      rd(1, 3, v); chk("R1 count wrap", v, 300 % 256);
      wait_n(256);
      rd(0, 3, v); chk("R1 count full period", v, 300 % 256);

      // R2 enable readback
      for (int c = 0; c < NC; c++) begin
         wr(c, 0, 1);
         rd(c, 0, v); chk("R2 enable read", v, 1);
      end

      // delta sweep, one-shot, clear
      for (int c = 0; c < NC; c++) begin
         foreach (deltas[j]) begin
            fire(c, deltas[j]);
            rd(c, 1, v); chk("R7 status read", v, 1);
            wr(c, 1, 0);
            chk("R7 cleared", 32'(irq[c]), 0);
            wait_n(deltas[j] + 3);
            chk("R5 no refire", 32'(irq[c]), 0);
         end
      end
      wait_n(300);
      chk("R5 long idle", 32'(irq), 0);

      // R4 cancel and restart
      wr(0, 6, 20);
      wait_n(5);
      fire(0, 30);
      wr(0, 1, 0);
      wr(0, 6, 40);
      wait_n(3);
      wr(0, 6, 4);
      wait_n(3);
      chk("R4 restart not yet", 32'(irq[0]), 0);
      wait_n(1);
      chk("R4 restart fired", 32'(irq[0]), 1);
      wr(0, 1, 0);
      wait_n(60);
      chk("R4 old expiry gone", 32'(irq[0]), 0);

      // R6 gating and hold
      wr(1, 0, 0);
      wr(1, 6, 4);
      wait_n(10);
      chk("R6 disabled expiry", 32'(irq[1]), 0);
      rd(1, 1, v); chk("R6 disabled status", v, 0);
      wr(1, 0, 1);
      wait_n(5);
      chk("R5 no late fire", 32'(irq[1]), 0);
      fire(1, 6);
      wr(1, 0, 0);
      chk("R6 held after disable", 32'(irq[1]), 1);
      rd(1, 0, v); chk("R2 disable read", v, 0);
      wr(1, 1, 5);
      chk("R7 nonzero ignored", 32'(irq[1]), 1);
      wr(1, 1, 0);
      chk("R7 zero clears", 32'(irq[1]), 0);
      wr(1, 0, 1);

      // R10 zero delta
      wr(0, 6, 5);
      wait_n(2);
      wr(0, 6, 0);
      wait_n(10);
      chk("R10 zero delta", 32'(irq[0]), 0);

      // R11 clear on expiry edge
      wr(0, 6, 3);
      wait_n(2);
      wr(0, 1, 0);
      chk("R11 expiry beats clear", 32'(irq[0]), 1);
      wr(0, 1, 0);

      // R8 reads and unused writes
      wr(0, 6, 50);
      rd(0, 6, v); chk("R8 reload reads zero", v, 0);
      rd(0, 2, v); chk("R8 unused 2", v, 0);
      rd(0, 7, v); chk("R8 unused 7", v, 0);
      rd(0, 12, v); chk("R8 unused 12", v, 0);
      wr(0, 1, 0);
      wr(0, 2, 255); wr(0, 4, 0); wr(0, 5, 0); wr(0, 8, 0); wr(0, 14, 0);
      rd(0, 0, v); chk("R8 enable kept", v, 1);
      wait_n(60);
      chk("R8 countdown kept", 32'(irq[0]), 1);
      wr(0, 1, 0);

      // R9 independence
      wr(1, 6, 10);
      wr(0, 6, 3);
      wait_n(2);
      chk("R9 core0 not yet", 32'(irq[0]), 0);
      wait_n(1);
      chk("R9 core0 fired", 32'(irq[0]), 1);
      chk("R9 core1 waiting", 32'(irq[1]), 0);
      wr(0, 1, 0);
      wr(0, 0, 0);
      wait_n(4);
      chk("R9 core1 fired", 32'(irq[1]), 1);
      rd(1, 0, v); chk("R9 core1 enable", v, 1);

      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule